// File: doc/BRIEF.md
# GPIO Interrupt Router

This block is a memory-mapped general-purpose I/O port of up to 32 lines, reached through 32-bit registers on a simple two-phase peripheral bus (select, then enable). Every line has a direction bit, an output latch and a readable input value. In each register word, bit n belongs to line n. Pad inputs pass through a two-flop synchroniser before software or the interrupt logic sees them.

Any line can also raise an interrupt. Three per-line bits decide this: an enable bit, a polarity bit and an edge-select bit. Together they give level-low, level-high, falling-edge or rising-edge triggering. A routing table gives each line one byte, which names the interrupt output it drives or marks it as not routed. Each interrupt output is the OR of every enabled, triggered line routed to it.

A small state machine follows the bus phases. Its states are BUS_IDLE, BUS_SETUP and BUS_ACCESS. The transitions are:
- BUS_IDLE to BUS_SETUP when select rises without enable.
- BUS_SETUP to BUS_ACCESS when enable joins select.
- BUS_SETUP stays in BUS_SETUP while select is held without enable, and drops to BUS_IDLE when select falls.
- BUS_ACCESS to BUS_SETUP on a back-to-back select without enable, and to BUS_IDLE otherwise.

A write is committed only on the BUS_SETUP to BUS_ACCESS transition.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, every line is an input (pad_oe zero), the output, enable, polarity, edge and bypass registers read 0, every routing byte reads 0xFF, and every irq_out bit is 0.
- R2: Output (0x04), direction (0x08), enable (0x0C), polarity (0x10), edge (0x14) and bypass (0x18) registers read back what was written. Bits at and above NLINES read as 0.
- R3: pad_out follows the output register and pad_oe follows the direction register (1 = drive), from the cycle after the write commits.
- R4: Reading offset 0x00 returns the pad inputs after a two-flop synchroniser. Writes to 0x00 have no effect.
- R5: Polarity/edge 0/0 is level-low and 1/0 is level-high. While an enabled line sits at its active level, its routed output is held at 1, starting on the third rising clock edge after the pad change.
- R6: Polarity/edge 1/1 is rising edge and 0/1 is falling edge. A matching pad transition gives a one-cycle pulse on the routed output, on the third rising edge after the change. A transition in the other direction gives nothing.
- R7: A line whose enable bit (0x0C) is 0 never affects any irq_out bit.
- R8: The routing table starts at 0x20 and packs four bytes per word: line n sits in word n/4 (offset 0x20+4*(n/4)), bits 8*(n%4)+7 down to 8*(n%4). A byte value j below NIRQ routes the line to irq_out[j]. 0xFF, or any value not below NIRQ, leaves it unrouted.
- R9: Each irq_out bit is the OR of all enabled, triggered lines routed to it. It stays high while any one of them remains active.
- R10: A write is committed only when an enable phase directly follows a setup phase. An access that raises select and enable together without a setup cycle changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus enable (second phase) |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while select is high on a read |
| pad_in | input | NLINES | Pad input values |
| pad_out | output | NLINES | Output register driven to the pads |
| pad_oe | output | NLINES | Per-line drive enable |
| irq_out | output | NIRQ | Routed interrupt outputs |

## Verification
Each result has a fixed delay after its stimulus:
- A register write takes effect on the rising edge that ends its setup-to-access transition. Read data appears combinationally in the following access.
- A pad change reaches the data register after two rising edges and reaches irq_out on the third.
- An edge pulse falls again on the fourth.
- A change to an enable or routing byte reaches irq_out one edge after the commit.

The bench drives and samples only on falling edges. It counts whole cycles from each stimulus to the edge where the result is due, and also checks the cycle after, so that a pulse one cycle too long or late is caught.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned REG_W = 32;

    localparam int unsigned OFF_DATA = 32'h00;
    localparam int unsigned OFF_OUT  = 32'h04;
    localparam int unsigned OFF_DIR  = 32'h08;
    localparam int unsigned OFF_MASK = 32'h0C;
    localparam int unsigned OFF_POL  = 32'h10;
    localparam int unsigned OFF_EDGE = 32'h14;
    localparam int unsigned OFF_BYP  = 32'h18;
    localparam int unsigned OFF_MAP  = 32'h20;

    localparam logic [7:0] ROUTE_NONE = 8'hFF;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_SETUP  = 2'd1,
        BUS_ACCESS = 2'd2
    } bus_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NLINES = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    psel,
    input  logic                    penable,
    input  logic                    pwrite,
    input  logic [ADDR_W-1:0]       paddr,
    input  logic [REG_W-1:0]        pwdata,
    output logic [REG_W-1:0]        prdata,
    input  logic [NLINES-1:0]       sync_in,
    output logic [NLINES-1:0]       out_q,
    output logic [NLINES-1:0]       dir_q,
    output logic [NLINES-1:0]       mask_q,
    output logic [NLINES-1:0]       pol_q,
    output logic [NLINES-1:0]       edge_q,
    output logic [NLINES-1:0][7:0]  map_q,
    output bus_state_e              bus_state
);

    localparam int unsigned MAP_WORDS = (NLINES + 3) / 4;
    localparam int unsigned MAP_END   = OFF_MAP + 4 * MAP_WORDS;

    bus_state_e        state_q;
    bus_state_e        state_d;
    logic              commit;
    logic              rd_en;
    logic [NLINES-1:0] byp_q;
    logic [REG_W-1:0]  rd_word;
    int unsigned       addr_i;

    assign addr_i = int'(paddr);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (psel && !penable) state_d = BUS_SETUP;
            end
            BUS_SETUP: begin
                if (psel && penable)  state_d = BUS_ACCESS;
                else if (!psel)       state_d = BUS_IDLE;
            end
            BUS_ACCESS: begin
                if (psel && !penable) state_d = BUS_SETUP;
                else                  state_d = BUS_IDLE;
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        commit = 1'b0;
        rd_en  = 1'b0;
        unique case (state_q)
            BUS_IDLE:   rd_en  = psel && !pwrite;
            BUS_SETUP: begin
                commit = psel && penable && pwrite;
                rd_en  = psel && !pwrite;
            end
            BUS_ACCESS: rd_en  = psel && !pwrite;
            default: begin
                commit = 1'b0;
                rd_en  = 1'b0;
            end
        endcase
    end

    assign bus_state = state_q;

    // Line-wide registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
            pol_q  <= '0;
            edge_q <= '0;
            byp_q  <= '0;
        end else if (commit) begin
            case (addr_i)
                OFF_OUT:  out_q  <= pwdata[NLINES-1:0];
                OFF_DIR:  dir_q  <= pwdata[NLINES-1:0];
                OFF_MASK: mask_q <= pwdata[NLINES-1:0];
                OFF_POL:  pol_q  <= pwdata[NLINES-1:0];
                OFF_EDGE: edge_q <= pwdata[NLINES-1:0];
                OFF_BYP:  byp_q  <= pwdata[NLINES-1:0];
                default: ;
            endcase
        end
    end

    // Routing bytes, four per word
    genvar gi;
    generate
        for (gi = 0; gi < NLINES; gi++) begin : g_map
            localparam int unsigned WORD_ADDR = OFF_MAP + 4 * (gi / 4);
            localparam int unsigned LANE      = gi % 4;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    map_q[gi] <= ROUTE_NONE;
                else if (commit && addr_i == WORD_ADDR)
                    map_q[gi] <= pwdata[8*LANE +: 8];
            end
        end
    endgenerate

    // Read multiplexer
    always_comb begin
        rd_word = '0;
        case (addr_i)
            OFF_DATA: rd_word = REG_W'(sync_in);
            OFF_OUT:  rd_word = REG_W'(out_q);
            OFF_DIR:  rd_word = REG_W'(dir_q);
            OFF_MASK: rd_word = REG_W'(mask_q);
            OFF_POL:  rd_word = REG_W'(pol_q);
            OFF_EDGE: rd_word = REG_W'(edge_q);
            OFF_BYP:  rd_word = REG_W'(byp_q);
            default: begin
                if (addr_i >= OFF_MAP && addr_i < MAP_END) begin
                    for (int i = 0; i < int'(NLINES); i++) begin
                        if (addr_i == OFF_MAP + 4 * (i / 4))
                            rd_word[8*(i%4) +: 8] = map_q[i];
                    end
                end
            end
        endcase
    end

    assign prdata = rd_en ? rd_word : '0;

endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
    parameter int unsigned NLINES = 32,
    parameter int unsigned NIRQ   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NLINES-1:0]      sync_in,
    input  logic [NLINES-1:0]      mask,
    input  logic [NLINES-1:0]      pol,
    input  logic [NLINES-1:0]      edge_sel,
    input  logic [NLINES-1:0][7:0] map,
    output logic [NIRQ-1:0]        irq_out
);

    logic [NLINES-1:0]            prev_q;
    logic [NLINES-1:0]            level_hit;
    logic [NLINES-1:0]            edge_hit;
    logic [NLINES-1:0]            hit;
    logic [NIRQ-1:0][NLINES-1:0]  route;
    logic [NIRQ-1:0]              irq_d;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    always_comb begin
        for (int i = 0; i < int'(NLINES); i++) begin
            level_hit[i] = pol[i] ? sync_in[i] : ~sync_in[i];
            edge_hit[i]  = pol[i] ? (sync_in[i] & ~prev_q[i])
                                  : (~sync_in[i] & prev_q[i]);
        end
        hit = mask & ((edge_sel & edge_hit) | (~edge_sel & level_hit));
    end

    genvar gj, gl;
    generate
        for (gj = 0; gj < NIRQ; gj++) begin : g_out
            for (gl = 0; gl < NLINES; gl++) begin : g_line
                assign route[gj][gl] = (map[gl] == 8'(gj));
            end
            assign irq_d[gj] = |(hit & route[gj]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= '0;
        else        irq_out <= irq_d;
    end

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NLINES = 32,
    parameter int unsigned NIRQ   = 4,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe,
    output logic [NIRQ-1:0]   irq_out
);

    logic [NLINES-1:0]      sync_val;
    logic [NLINES-1:0]      out_q;
    logic [NLINES-1:0]      dir_q;
    logic [NLINES-1:0]      mask_q;
    logic [NLINES-1:0]      pol_q;
    logic [NLINES-1:0]      edge_q;
    logic [NLINES-1:0][7:0] map_q;
    bus_state_e             bus_state;

    gpio_sync #(.W(NLINES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_val)
    );

    gpio_regfile #(.NLINES(NLINES), .ADDR_W(ADDR_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .sync_in   (sync_val),
        .out_q     (out_q),
        .dir_q     (dir_q),
        .mask_q    (mask_q),
        .pol_q     (pol_q),
        .edge_q    (edge_q),
        .map_q     (map_q),
        .bus_state (bus_state)
    );

    gpio_irq_route #(.NLINES(NLINES), .NIRQ(NIRQ)) i_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_val),
        .mask     (mask_q),
        .pol      (pol_q),
        .edge_sel (edge_q),
        .map      (map_q),
        .irq_out  (irq_out)
    );

    assign pad_out = out_q;
    assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NLINES = 32,
    parameter int unsigned NIRQ   = 4,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       pwdata,
    input logic [31:0]       prdata,
    input logic [NLINES-1:0] pad_in,
    input logic [NLINES-1:0] pad_out,
    input logic [NLINES-1:0] pad_oe,
    input logic [NIRQ-1:0]   irq_out,
    input bus_state_e        bus_state,
    input logic [NLINES-1:0] mask_q
);

    logic [1:0] age_q;
    logic       setup_wr;

    always_ff @(posedge clk) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assign setup_wr = (bus_state == BUS_SETUP) && psel && penable && pwrite;

    // R3: drive enables take the written value one cycle after commit
    p_oe_takes_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_wr && paddr == ADDR_W'(OFF_DIR)) |=> (pad_oe == $past(pwdata[NLINES-1:0])));

    // R3: output pins take the written value one cycle after commit
    p_out_takes_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_wr && paddr == ADDR_W'(OFF_OUT)) |=> (pad_out == $past(pwdata[NLINES-1:0])));

    // R10: an access with no preceding setup phase leaves the drive enables alone
    p_bare_access_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == BUS_IDLE && psel && penable && pwrite) |=> $stable(pad_oe));

    // R7: with every enable bit clear in the previous cycle, no output fires
    p_disabled_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mask_q) == '0) |-> (irq_out == '0));

    // R4: a data read reports the pad value from two cycles earlier
    p_data_synced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && psel && !pwrite && paddr == ADDR_W'(OFF_DATA))
            |-> (prdata[NLINES-1:0] == $past(pad_in, 2)));

endmodule

bind gpio_irq_router gpio_irq_router_chk #(
    .NLINES (NLINES),
    .NIRQ   (NIRQ),
    .ADDR_W (ADDR_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq_out   (irq_out),
    .bus_state (bus_state),
    .mask_q    (mask_q)
);

// File: tb/test_gpio_irq_router.sv
`timescale 1ns/1ps
module test_gpio_irq_router;

    localparam int unsigned NL = 20;
    localparam int unsigned NI = 3;
    localparam int unsigned AW = 8;
    localparam int unsigned LN = 5;   // line under table test, routed to output 1

    // {pol, edge, pad_before, pad_after, irq_at_3rd_edge, irq_at_4th_edge}
    localparam logic [5:0] VEC [0:6] = '{
        6'b10_01_11,   // level-high, pad rises
        6'b00_10_11,   // level-low, pad falls
        6'b11_01_10,   // rising edge, pad rises
        6'b01_10_10,   // falling edge, pad falls
        6'b11_10_00,   // rising edge, pad falls
        6'b01_01_00,   // falling edge, pad rises
        6'b10_00_00    // level-high, pad stays low
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic [NL-1:0] pad_in = '0;
    logic [NL-1:0] pad_out;
    logic [NL-1:0] pad_oe;
    logic [NI-1:0] irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] rd;

    always #2 clk = ~clk;

    gpio_irq_router #(.NLINES(NL), .NIRQ(NI), .ADDR_W(AW)) i_gpio_irq_router (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = AW'(a); pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = AW'(a);
        @(negedge clk);
        penable = 1'b1;
        d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1: reset state
        check("R1 pad_oe", 32'(pad_oe), 32'h0);
        check("R1 irq_out", 32'(irq_out), 32'h0);
        rd_reg(8'h04, rd); check("R1 out", rd, 32'h0);
        rd_reg(8'h0C, rd); check("R1 enable", rd, 32'h0);
        rd_reg(8'h10, rd); check("R1 pol", rd, 32'h0);
        rd_reg(8'h18, rd); check("R1 bypass", rd, 32'h0);
        rd_reg(8'h20, rd); check("R1 map word0", rd, 32'hFFFF_FFFF);
        rd_reg(8'h30, rd); check("R1 map word4", rd, 32'hFFFF_FFFF);

        // R2/R3: readback, upper bits zero, pins follow
        wr(8'h08, 32'hFFFF_FFFF);
        rd_reg(8'h08, rd); check("R2 dir upper bits", rd, 32'h000F_FFFF);
        check("R3 pad_oe", 32'(pad_oe), 32'h000F_FFFF);
        wr(8'h04, 32'hA5A5_A5A5);
        rd_reg(8'h04, rd); check("R2 out", rd, 32'h0005_A5A5);
        check("R3 pad_out", 32'(pad_out), 32'h0005_A5A5);
        wr(8'h18, 32'h1234_5678);
        rd_reg(8'h18, rd); check("R2 bypass", rd, 32'h0004_5678);
        wr(8'h14, 32'h0000_0F0F);
        rd_reg(8'h14, rd); check("R2 edge", rd, 32'h0000_0F0F);
        wr(8'h08, 32'h0); wr(8'h04, 32'h0); wr(8'h14, 32'h0);
        check("R3 pad_oe cleared", 32'(pad_oe), 32'h0);

        // R4: synchronised data, writes ignored
        pad_in = 20'h3C3C3;
        cyc(3);
        rd_reg(8'h00, rd); check("R4 data read", rd, 32'h0003_C3C3);
        wr(8'h00, 32'hFFFF_FFFF);
        rd_reg(8'h00, rd); check("R4 data write ignored", rd, 32'h0003_C3C3);
        pad_in = '0;
        cyc(3);

        // R10: select and enable together with no setup phase
        @(negedge clk);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = AW'(8'h08); pwdata = 32'hFFFF_FFFF;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        rd_reg(8'h08, rd); check("R10 bare access ignored", rd, 32'h0);

        // R8: 0xFF unrouted (line 0 level-high active)
        pad_in[0] = 1'b1;
        wr(8'h10, 32'h1); wr(8'h0C, 32'h1);
        cyc(4);
        check("R8 0xFF unrouted", 32'(irq_out), 32'h0);
        wr(8'h0C, 32'h0); pad_in[0] = 1'b0; wr(8'h10, 32'h0);

        // R8: byte lanes of word 1; value 3 (not below NIRQ) unrouted
        wr(8'h24, 32'h0303_0103);
        rd_reg(8'h24, rd); check("R8 map readback", rd, 32'h0303_0103);
        pad_in[6] = 1'b1;
        wr(8'h10, 32'h40); wr(8'h0C, 32'h40);
        cyc(4);
        check("R8 value >= NIRQ unrouted", 32'(irq_out), 32'h0);
        wr(8'h24, 32'h0302_0103);   // line 6 (byte 2) -> output 2
        cyc(1);
        check("R8 line6 to irq2", 32'(irq_out), 32'h4);

        // R7: disabling the line drops it
        wr(8'h0C, 32'h0);
        cyc(1);
        check("R7 disabled line", 32'(irq_out), 32'h0);

        // R9: two lines OR onto output 2
        wr(8'h24, 32'h0302_0102);   // line 4 and line 6 -> output 2
        pad_in[4] = 1'b1;
        wr(8'h10, 32'h50); wr(8'h0C, 32'h50);
        cyc(3);
        check("R9 both active", 32'(irq_out), 32'h4);
        pad_in[4] = 1'b0;
        cyc(4);
        check("R9 one still active", 32'(irq_out), 32'h4);
        pad_in[6] = 1'b0;
        cyc(4);
        check("R9 none active", 32'(irq_out), 32'h0);
        wr(8'h0C, 32'h0); wr(8'h10, 32'h0);

        // R5/R6: trigger table on line 5 -> output 1
        wr(8'h24, 32'h0303_0103);
        for (int v = 0; v < 7; v++) begin
            logic [5:0] e;
            string tag;
            e = VEC[v];
            tag = e[4] ? $sformatf("R6 vec%0d", v) : $sformatf("R5 vec%0d", v);
            wr(8'h0C, 32'h0);
            pad_in[LN] = e[3];
            cyc(4);
            wr(8'h10, 32'(e[5]) << LN);
            wr(8'h14, 32'(e[4]) << LN);
            wr(8'h0C, 32'h1 << LN);
            cyc(3);
            check({tag, " idle"}, 32'(irq_out), 32'h0);
            pad_in[LN] = e[2];
            cyc(2);
            check({tag, " before due"}, 32'(irq_out), 32'h0);
            cyc(1);
            check({tag, " due"}, 32'(irq_out), 32'(e[1]) << 1);
            cyc(1);
            check({tag, " next"}, 32'(irq_out), 32'(e[0]) << 1);
        end

        finish_run();
    end

endmodule